// File: doc/BRIEF.md
# Synchronous FIFO with Peek, Held Slots and Last-Entry Overwrite

This block is a single-clock FIFO whose read side separates three actions that an ordinary FIFO merges: seeing the oldest entry, taking it off the read side, and giving its storage back to the writer. A reader can peek without side effects, take an entry while freeing its slot at once, or take an entry while keeping its slot held. The holder later returns all held slots in one finish operation. A separate finish port can also discard the oldest entry and free its slot, without returning data.

The write side either appends a new entry or replaces the most recently written entry that is still unread. Replacement costs no free space, so a producer can keep refreshing the newest value while the reader is stalled. Every port reports success in the same cycle as the request. Two status outputs tell whether an append and a read would currently succeed. Writer space is counted from a release pointer, so held slots stay unavailable until they are returned.

Top module: `peek_release_fifo`

## Requirements
- R1: After reset the FIFO is empty with no held slots: canGet is 0, canPut is 1, and no read or pop succeeds.
- R2: A write with wrMode=0 (append) is accepted when fewer than DEPTH slots are in use (unread plus held), and it is refused otherwise. An accepted entry is queued behind older ones and becomes readable in the following cycle, not in the cycle it is written.
- R3: A read with rdMode=0 (get) returns the oldest unread entry on rdData, removes it, and returns its slot to the writer, so canPut is 1 in the next cycle.
- R4: A read with rdMode=1 (shrink) returns and removes the oldest unread entry, but its slot stays in use: it is not available to the writer until an unshrink.
- R5: A read with rdMode=2 (peek) returns the oldest unread entry and changes nothing, so the same entry is returned by the next read.
- R6: A finish with finMode=0 (unshrink) frees every slot held by shrinks from earlier cycles. It succeeds only if at least one slot is held. A shrink in the same cycle stays held.
- R7: A finish with finMode=1 (pop) removes the oldest unread entry and frees its slot. The read port has priority: the pop succeeds only if an unread entry remains after that cycle's read, and it then removes the entry behind the one the read took.
- R8: A write with wrMode=1 (overwrite) replaces the newest entry and is always accepted when an unread entry remains after that cycle's read and pop, even when no slot is free. When no unread entry remains, it behaves exactly as an append.
- R9: A read on an empty read side, or with the unused rdMode=3, returns rdOk=0 and leaves all state unchanged.
- R10: wrAccept, rdOk and finOk respond in the same cycle as the request. canPut equals "an append would be accepted" and canGet equals "unread entry present", both derived from state at the start of the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| wrValid | input | 1 | Write request |
| wrMode | input | 1 | 0 append, 1 overwrite newest |
| wrData | input | DATA_W | Write data |
| wrAccept | output | 1 | Write succeeded this cycle |
| rdValid | input | 1 | Read request |
| rdMode | input | 2 | 0 get, 1 shrink, 2 peek, 3 unused |
| rdData | output | DATA_W | Oldest unread entry |
| rdOk | output | 1 | Read succeeded this cycle |
| finValid | input | 1 | Finish request |
| finMode | input | 1 | 0 unshrink, 1 pop |
| finOk | output | 1 | Finish succeeded this cycle |
| canPut | output | 1 | An append would succeed |
| canGet | output | 1 | A read would succeed |

## Verification
The success flags and rdData are combinational on the current requests, so they are due in the request cycle itself. Pointer and storage effects show up on canPut, canGet and rdData one rising edge later. The bench applies each request on the falling edge and compares the flags and data 1 ns later, before the rising edge. It then advances its own queue model at that edge, so the next comparison covers the state-change effects. A long randomized sweep over a four-entry instance reaches full, empty, held-only and all concurrent port combinations, after directed sequences that reach each corner.

// File: rtl/prf_pkg.sv
package prf_pkg;
  // read port operation codes
  localparam logic [1:0] RD_GET    = 2'd0;
  localparam logic [1:0] RD_SHRINK = 2'd1;
  localparam logic [1:0] RD_PEEK   = 2'd2;
  // write port operation codes
  localparam logic WR_APPEND = 1'b0;
  localparam logic WR_OVER   = 1'b1;
  // finish port operation codes
  localparam logic FIN_UNSHRINK = 1'b0;
  localparam logic FIN_POP      = 1'b1;

  // strobes from control to storage
  typedef struct packed {
    logic wrEn;     // write storage this cycle
    logic replace;  // target the newest slot instead of the next free one
  } prfStrobe_t;
endpackage

// File: rtl/prf_store.sv
module prf_store
  import prf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  prfStrobe_t        strobe,
  input  logic [AW-1:0]     appendIdx,
  input  logic [AW-1:0]     headIdx,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0] wrIdx;

  always_comb begin
    wrIdx = strobe.replace ? appendIdx - AW'(1) : appendIdx;
  end

  always_ff @(posedge clk) begin
    if (strobe.wrEn) mem[wrIdx] <= wrData;
  end

  assign rdData = mem[headIdx];
endmodule

// File: rtl/prf_ctrl.sv
module prf_ctrl
  import prf_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrValid,
  input  logic          wrMode,
  output logic          wrAccept,
  input  logic          rdValid,
  input  logic [1:0]    rdMode,
  output logic          rdOk,
  input  logic          finValid,
  input  logic          finMode,
  output logic          finOk,
  output logic          canPut,
  output logic          canGet,
  output prfStrobe_t    strobe,
  output logic [AW-1:0] appendIdx,
  output logic [AW-1:0] headIdx
);
  // DEPTH must be a power of two: pointers carry one wrap bit
  logic [PW-1:0] wrPtr, rdPtr, relPtr;
  logic [PW-1:0] unread, held, used;
  logic [PW-1:0] afterRd, remain;
  logic rdLegal, rdRemove, rdFree, popOk, unshOk, doReplace, doAppend;

  always_comb begin
    unread   = wrPtr - rdPtr;
    held     = rdPtr - relPtr;
    used     = wrPtr - relPtr;
    canGet   = unread != '0;
    canPut   = used < PW'(DEPTH);

    rdLegal  = rdMode != 2'd3;
    rdOk     = rdValid && rdLegal && canGet;
    rdRemove = rdOk && (rdMode != RD_PEEK);
    rdFree   = rdOk && (rdMode == RD_GET);

    afterRd  = unread - PW'(rdRemove);
    popOk    = finValid && (finMode == FIN_POP) && (afterRd != '0);
    unshOk   = finValid && (finMode == FIN_UNSHRINK) && (held != '0);
    finOk    = popOk || unshOk;

    remain    = afterRd - PW'(popOk);
    doReplace = wrValid && (wrMode == WR_OVER) && (remain != '0);
    doAppend  = wrValid && !doReplace && canPut;
    wrAccept  = doReplace || doAppend;

    strobe.wrEn    = wrAccept;
    strobe.replace = doReplace;
    appendIdx      = wrPtr[AW-1:0];
    headIdx        = rdPtr[AW-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      relPtr <= '0;
    end else begin
      wrPtr <= wrPtr + PW'(doAppend);
      rdPtr <= rdPtr + PW'(rdRemove) + PW'(popOk);
      if (unshOk) relPtr <= rdPtr + PW'(rdFree);
      else        relPtr <= relPtr + PW'(rdFree) + PW'(popOk);
    end
  end
endmodule

// File: rtl/peek_release_fifo.sv
module peek_release_fifo
  import prf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic              wrMode,
  input  logic [DATA_W-1:0] wrData,
  output logic              wrAccept,
  input  logic              rdValid,
  input  logic [1:0]        rdMode,
  output logic [DATA_W-1:0] rdData,
  output logic              rdOk,
  input  logic              finValid,
  input  logic              finMode,
  output logic              finOk,
  output logic              canPut,
  output logic              canGet
);
  localparam int AW = $clog2(DEPTH);

  prfStrobe_t    strobe;
  logic [AW-1:0] appendIdx, headIdx;

  prf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .wrValid(wrValid), .wrMode(wrMode), .wrAccept(wrAccept),
    .rdValid(rdValid), .rdMode(rdMode), .rdOk(rdOk),
    .finValid(finValid), .finMode(finMode), .finOk(finOk),
    .canPut(canPut), .canGet(canGet),
    .strobe(strobe), .appendIdx(appendIdx), .headIdx(headIdx)
  );

  prf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .strobe(strobe), .appendIdx(appendIdx), .headIdx(headIdx),
    .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: rtl/prf_checker.sv
module prf_checker (
  input logic       clk,
  input logic       rstN,
  input logic       wrValid,
  input logic       wrMode,
  input logic       wrAccept,
  input logic       rdValid,
  input logic [1:0] rdMode,
  input logic       rdOk,
  input logic       finValid,
  input logic       finMode,
  input logic       finOk,
  input logic       canPut,
  input logic       canGet
);
  // R2
  append_full_refused_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && wrMode == 1'b0 && !canPut) |-> !wrAccept);

  // R3
  get_frees_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdOk && rdMode == 2'd0) |=> canPut);

  // R4
  shrink_keeps_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!canPut && rdValid && rdMode == 2'd1 && !finValid) |=> !canPut);

  // R5
  peek_keeps_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdOk && rdMode == 2'd2 && !finValid) |=> canGet);

  // R6
  unshrink_frees_chk: assert property (@(posedge clk) disable iff (!rstN)
    (finValid && finMode == 1'b0 && finOk) |=> canPut);

  // R8
  overwrite_no_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && wrMode == 1'b1 && canGet && !rdValid && !finValid) |-> wrAccept);

  // R9
  empty_read_fails_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!canGet || rdMode == 2'd3) |-> !rdOk);

  // R10
  get_drop_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(canGet) |-> $past(rdOk || finOk));
endmodule

bind peek_release_fifo prf_checker u_chk (.*);

// File: tb/peek_release_fifo_bench.sv
`timescale 1ns/1ps
module peek_release_fifo_bench;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrValid = 0, wrMode = 0, rdValid = 0, finValid = 0, finMode = 0;
  logic [1:0] rdMode = 0;
  logic [DATA_W-1:0] wrData = 0;
  logic [DATA_W-1:0] rdData;
  logic wrAccept, rdOk, finOk, canPut, canGet;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // reference model: unread entries and count of held slots
  int q[$];
  int heldCnt = 0;

  always #2.5 clk = ~clk;

  peek_release_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_peek_release_fifo (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // apply one cycle of requests at the falling edge, check, advance model
  task automatic step(input bit wv, input bit wm, input int wd,
                      input bit rv, input int rm, input bit fv, input bit fm);
    int unread, nFree, remain;
    bit eRd, eRemove, eShrink, ePop, eUnsh, eRepl, eWr;
    int eData;
    string rq;
    wrValid = wv; wrMode = wm; wrData = DATA_W'(wd);
    rdValid = rv; rdMode = 2'(rm); finValid = fv; finMode = fm;
    #1;
    unread  = q.size();
    nFree   = DEPTH - unread - heldCnt;
    eRd     = rv && unread > 0 && rm != 3;
    eRemove = eRd && rm != 2;
    eShrink = eRd && rm == 1;
    ePop    = fv && fm && (unread - int'(eRemove)) > 0;
    eUnsh   = fv && !fm && heldCnt > 0;
    remain  = unread - int'(eRemove) - int'(ePop);
    eRepl   = wv && wm && remain > 0;
    eWr     = eRepl || (wv && nFree > 0);
    eData   = (unread > 0) ? q[0] : 0;

    rq = (rm == 3 || unread == 0) ? "R9" : (rm == 0) ? "R3" : (rm == 1) ? "R4" : "R5";
    check(rdOk == eRd, rq, rdOk, eRd);
    if (eRd) check(rdData == DATA_W'(eData), rq, rdData, eData);
    check(finOk == (ePop || eUnsh), fm ? "R7" : "R6", finOk, ePop || eUnsh);
    check(wrAccept == eWr, wm ? "R8" : "R2", wrAccept, eWr);
    check(canPut == (nFree > 0), "R10", canPut, nFree > 0);
    check(canGet == (unread > 0), "R10", canGet, unread > 0);

    if (eRemove) void'(q.pop_front());
    if (ePop) void'(q.pop_front());
    heldCnt = (eUnsh ? 0 : heldCnt) + int'(eShrink);
    if (eRepl) q[q.size()-1] = wd & 8'hFF;
    else if (eWr) q.push_back(wd & 8'hFF);
    @(posedge clk);
    @(negedge clk);
    wrValid = 0; rdValid = 0; finValid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(canGet == 0, "R1", canGet, 0);
    check(canPut == 1, "R1", canPut, 1);
    rstN = 1'b1;
    @(negedge clk);
    step(0,0,0, 1,0, 1,1);            // R1/R9: read and pop on empty
    // R2: fill, fifth append refused; same-cycle read not possible
    step(1,0,8'h11, 1,0, 0,0);
    step(1,0,8'h22, 0,0, 0,0);
    step(1,0,8'h33, 0,0, 0,0);
    step(1,0,8'h44, 0,0, 0,0);
    step(1,0,8'h55, 0,0, 0,0);
    // R8: overwrite while full
    step(1,1,8'h66, 0,0, 0,0);
    // R5: peek twice
    step(0,0,0, 1,2, 0,0);
    step(0,0,0, 1,2, 0,0);
    // R4: shrink, slot still used
    step(0,0,0, 1,1, 0,0);
    step(1,0,8'h77, 1,1, 0,0);
    // R6: unshrink frees both
    step(0,0,0, 0,0, 1,0);
    step(0,0,0, 0,0, 1,0);            // nothing held: fails
    // R7: pop with concurrent get
    step(1,0,8'h88, 1,0, 1,1);
    step(0,0,0, 1,3, 0,0);            // R9: unused mode
    // R3: drain with gets
    repeat (4) step(0,0,0, 1,0, 0,0);
    // R8: overwrite on empty acts as append
    step(1,1,8'h99, 0,0, 0,0);
    step(1,1,8'hAA, 1,0, 0,0);        // read takes last: overwrite appends
    // randomized sweep
    for (int i = 0; i < 20000; i++) begin
      step($urandom_range(0,1), $urandom_range(0,1), $urandom_range(0,255),
           $urandom_range(0,1), $urandom_range(0,3),
           ($urandom_range(0,3) == 0), $urandom_range(0,1));
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule